// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for the management side of an Ethernet PHY. It sits behind two 32-bit registers on a simple register bus: a data register and a command register. To write a PHY register, software first loads the value into the data register and then writes a command word. To read one, software writes the command word alone. The command word carries a PHY address, a register number and a direction flag. On the clock edge after the command write, the block checks the address and applies the access to its small internal register file. A read leaves its result in the data register.

The internal file holds these registers:
- a writable control register with a self-clearing reset bit and a restart bit that is never stored;
- a status register, whose link bit follows the `link_up_i` input;
- two fixed identifier words;
- a writable advertisement register;
- a fixed link-partner ability word.

Every other register number reads as zero. Writes to registers that are not writable are dropped. A command aimed at any PHY address other than `phy_addr_i` is dropped without side effects.

Top module: `mgmt_phy_responder`

## Requirements
- R1: Command word fields are: PHY address in bits 15:12, register number in bits 7:4, write flag in bit 1 (1 = write, 0 = read), busy flag in bit 0. The command register reads back the value written, with bit 0 forced to 0.
- R2: A command executes on the first clock edge after the edge that stored it. Until that edge the data register keeps its previous contents.
- R3: A command whose PHY address differs from `phy_addr_i` changes nothing: no PHY register and not the data register.
- R4: The control register (number 0) resets to 0x3100. A write to it with data bit 15 set restores control to 0x3100 and advertisement to 0. The link bit is unaffected.
- R5: A control write with data bit 15 clear stores the data with bits 15 and 9 cleared (data & 0x7DFF).
- R6: The status register (number 1) reads 0xFE28, with bit 2 equal to `link_up_i` at the execution edge.
- R7: Register 2 reads 0x0044 and register 3 reads 0x1400. Writes to registers 2, 3 and 5 have no effect.
- R8: The advertisement register (number 4) resets to 0 and stores all 16 data bits on a write.
- R9: The link-partner register (number 5) always reads 0x0DE0.
- R10: Registers 6 to 15 read as 0. Writes to them and to register 1 have no effect.
- R11: The data register can be written over the bus with all 32 bits. A read command loads it with the 16-bit result zero-extended to 32 bits. A write command leaves it unchanged.
- R12: After reset, both the command register and the data register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phy_addr_i | input | 4 | PHY address this responder answers to |
| link_up_i | input | 1 | Link state reflected in status bit 2 |
| bus_we_i | input | 1 | Bus write strobe |
| bus_sel_i | input | 1 | Register select: 1 = command, 0 = data |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Contents of the selected register |

## Verification
Address matching is swept over all 16 configured addresses against all 16 command addresses. For each pair, the data register is preloaded with a marker, so a match (identifier returned) is distinguished from a mismatch (marker kept). Control and advertisement writes use a spread of values, some with bit 15 set and some with bit 9 set, which separates a plain store, a masked store and a self-reset. After writes to every read-only or unknown register number, all 16 registers are read back to expose any stray update. The status register is read with the link input both low and high.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;
  localparam int unsigned PHY_ADDR_W = 4;
  localparam int unsigned REG_IDX_W  = 4;
  localparam int unsigned PHY_REG_W  = 16;

  // command word layout
  localparam int unsigned CMD_ADDR_LSB = 12;
  localparam int unsigned CMD_REG_LSB  = 4;
  localparam int unsigned CMD_WR_BIT   = 1;
  localparam int unsigned CMD_BUSY_BIT = 0;

  localparam logic [REG_IDX_W-1:0] REG_CTRL    = 4'd0;
  localparam logic [REG_IDX_W-1:0] REG_STAT    = 4'd1;
  localparam logic [REG_IDX_W-1:0] REG_ID_HI   = 4'd2;
  localparam logic [REG_IDX_W-1:0] REG_ID_LO   = 4'd3;
  localparam logic [REG_IDX_W-1:0] REG_ADV     = 4'd4;
  localparam logic [REG_IDX_W-1:0] REG_PARTNER = 4'd5;

  localparam logic [PHY_REG_W-1:0] CTRL_RST_VAL  = 16'h3100;
  localparam logic [PHY_REG_W-1:0] CTRL_KEEP     = 16'h7DFF;
  localparam int unsigned          CTRL_SRST_BIT = 15;
  localparam logic [PHY_REG_W-1:0] STAT_FIXED    = 16'hFE28;
  localparam int unsigned          STAT_LINK_BIT = 2;
  localparam logic [PHY_REG_W-1:0] ID_HI_VAL     = 16'h0044;
  localparam logic [PHY_REG_W-1:0] ID_LO_VAL     = 16'h1400;
  localparam logic [PHY_REG_W-1:0] PARTNER_VAL   = 16'h0DE0;

  typedef struct packed {
    logic [PHY_ADDR_W-1:0] phy_addr;
    logic [REG_IDX_W-1:0]  reg_idx;
    logic                  wr;
  } mgmt_cmd_t;
endpackage

// File: rtl/mgmt_cmd_port.sv
module mgmt_cmd_port
  import mgmt_phy_pkg::*;
#(
  parameter int unsigned BUS_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic                 bus_sel_i,
  input  logic [BUS_W-1:0]     bus_wdata_i,
  output logic [BUS_W-1:0]     bus_rdata_o,
  output logic                 exec_o,
  output mgmt_cmd_t            cmd_o,
  output logic [PHY_REG_W-1:0] wr_data_o,
  input  logic                 rd_load_i,
  input  logic [PHY_REG_W-1:0] rd_data_i
);
  logic [BUS_W-1:0] cmd_q, data_q;
  logic             exec_q;
  logic             cmd_wr, data_wr;

  assign cmd_wr  = bus_we_i & bus_sel_i;
  assign data_wr = bus_we_i & ~bus_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      exec_q <= 1'b0;
    end else begin
      exec_q <= cmd_wr;
      if (cmd_wr) begin
        cmd_q               <= bus_wdata_i;
        cmd_q[CMD_BUSY_BIT] <= 1'b0;
      end
    end
  end

  // read result takes the data register over a concurrent bus write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (rd_load_i) data_q <= BUS_W'(rd_data_i);
    else if (data_wr)   data_q <= bus_wdata_i;
  end

  assign exec_o         = exec_q;
  assign cmd_o.phy_addr = cmd_q[CMD_ADDR_LSB +: PHY_ADDR_W];
  assign cmd_o.reg_idx  = cmd_q[CMD_REG_LSB +: REG_IDX_W];
  assign cmd_o.wr       = cmd_q[CMD_WR_BIT];
  assign wr_data_o      = data_q[PHY_REG_W-1:0];
  assign bus_rdata_o    = bus_sel_i ? cmd_q : data_q;

  AST_EXEC_AFTER_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |=> exec_o); // R2
  AST_READ_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load_i |=> (data_q[BUS_W-1:PHY_REG_W] == '0)); // R11
  AST_WRITE_CMD_KEEPS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && !rd_load_i && !data_wr) |=> $stable(data_q)); // R11
endmodule

// File: rtl/mgmt_phy_regfile.sv
module mgmt_phy_regfile
  import mgmt_phy_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PHY_ADDR_W-1:0] phy_addr_i,
  input  logic                  link_up_i,
  input  logic                  exec_i,
  input  mgmt_cmd_t             cmd_i,
  input  logic [PHY_REG_W-1:0]  wr_data_i,
  output logic                  rd_load_o,
  output logic [PHY_REG_W-1:0]  rd_data_o
);
  logic [PHY_REG_W-1:0] ctrl_q, adv_q, stat_val;
  logic                 hit, do_wr;

  assign hit       = exec_i && (cmd_i.phy_addr == phy_addr_i);
  assign do_wr     = hit && cmd_i.wr;
  assign rd_load_o = hit && !cmd_i.wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST_VAL;
      adv_q  <= '0;
    end else if (do_wr) begin
      case (cmd_i.reg_idx)
        REG_CTRL: begin
          if (wr_data_i[CTRL_SRST_BIT]) begin
            ctrl_q <= CTRL_RST_VAL;
            adv_q  <= '0;
          end else begin
            ctrl_q <= wr_data_i & CTRL_KEEP;
          end
        end
        REG_ADV: adv_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    stat_val                = STAT_FIXED;
    stat_val[STAT_LINK_BIT] = link_up_i;
    case (cmd_i.reg_idx)
      REG_CTRL:    rd_data_o = ctrl_q;
      REG_STAT:    rd_data_o = stat_val;
      REG_ID_HI:   rd_data_o = ID_HI_VAL;
      REG_ID_LO:   rd_data_o = ID_LO_VAL;
      REG_ADV:     rd_data_o = adv_q;
      REG_PARTNER: rd_data_o = PARTNER_VAL;
      default:     rd_data_o = '0;
    endcase
  end

  AST_MISMATCH_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && cmd_i.phy_addr != phy_addr_i) |=> ($stable(ctrl_q) && $stable(adv_q))); // R3
  AST_SELF_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_wr && cmd_i.reg_idx == REG_CTRL && wr_data_i[CTRL_SRST_BIT])
      |=> (ctrl_q == CTRL_RST_VAL && adv_q == '0)); // R4
  AST_RO_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_wr && cmd_i.reg_idx != REG_CTRL && cmd_i.reg_idx != REG_ADV)
      |=> ($stable(ctrl_q) && $stable(adv_q))); // R7
  AST_CTRL_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(ctrl_q) |-> (ctrl_q[9] == 1'b0)); // R5
endmodule

// File: rtl/mgmt_phy_responder.sv
module mgmt_phy_responder
  import mgmt_phy_pkg::*;
#(
  parameter int unsigned BUS_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PHY_ADDR_W-1:0] phy_addr_i,
  input  logic                  link_up_i,
  input  logic                  bus_we_i,
  input  logic                  bus_sel_i,
  input  logic [BUS_W-1:0]      bus_wdata_i,
  output logic [BUS_W-1:0]      bus_rdata_o
);
  mgmt_cmd_t            cmd;
  logic                 exec;
  logic                 rd_load;
  logic [PHY_REG_W-1:0] wr_data, rd_data;

  mgmt_cmd_port #(.BUS_W(BUS_W)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .exec_o      (exec),
    .cmd_o       (cmd),
    .wr_data_o   (wr_data),
    .rd_load_i   (rd_load),
    .rd_data_i   (rd_data)
  );

  mgmt_phy_regfile u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phy_addr_i (phy_addr_i),
    .link_up_i  (link_up_i),
    .exec_i     (exec),
    .cmd_i      (cmd),
    .wr_data_i  (wr_data),
    .rd_load_o  (rd_load),
    .rd_data_o  (rd_data)
  );

  AST_LOAD_ONLY_ON_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_load |-> exec); // R2
endmodule

// File: tb/tb_mgmt_phy_responder.sv
`timescale 1ns/1ps
module tb_mgmt_phy_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  phy_addr = 4'd0;
  logic        link_up = 1'b0;
  logic        bus_we = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int checks = 0;
  int errors = 0;
  logic [15:0] m_ctrl = 16'h3100;
  logic [15:0] m_adv = 16'h0000;

  always #4 clk = ~clk;

  mgmt_phy_responder dut (
    .clk_i(clk), .rst_ni(rst_n), .phy_addr_i(phy_addr), .link_up_i(link_up),
    .bus_we_i(bus_we), .bus_sel_i(bus_sel), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [31:0] val);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = val;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic sel, output logic [31:0] val);
    bus_sel = sel;
    #1;
    val = bus_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input logic [3:0] a, input logic [3:0] r, input logic wr);
    return {16'h0, a, 4'h0, r, 2'b00, wr, 1'b0};
  endfunction

  // issue command and wait until the execution edge has passed
  task automatic phy_cmd(input logic [3:0] a, input logic [3:0] r, input logic wr);
    bus_write(1'b1, cmd_word(a, r, wr));
    @(negedge clk);
  endtask

  function automatic logic [15:0] model_rd(input logic [3:0] r);
    case (r)
      4'd0: return m_ctrl;
      4'd1: return 16'hFE28 | (16'(link_up) << 2);
      4'd2: return 16'h0044;
      4'd3: return 16'h1400;
      4'd4: return m_adv;
      4'd5: return 16'h0DE0;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic read_check(input logic [3:0] r, input string req);
    logic [31:0] v;
    logic [31:0] e;
    bus_write(1'b0, 32'hFFFF_FFFF);
    phy_cmd(phy_addr, r, 1'b0);
    bus_read(1'b0, v);
    e = {16'h0, model_rd(r)};
    check(v == e, req, v, e);
  endtask

  task automatic phy_write(input logic [3:0] r, input logic [15:0] d);
    bus_write(1'b0, {16'h0, d});
    phy_cmd(phy_addr, r, 1'b1);
    if (r == 4'd0) begin
      if (d[15]) begin m_ctrl = 16'h3100; m_adv = 16'h0; end
      else m_ctrl = d & 16'h7DFF;
    end else if (r == 4'd4) m_adv = d;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    bus_read(1'b1, v); check(v == 32'h0, "R12 cmd", v, 32'h0);
    bus_read(1'b0, v); check(v == 32'h0, "R12 data", v, 32'h0);

    // R4 R8 reset values of writable registers
    read_check(4'd0, "R4 ctrl reset");
    read_check(4'd4, "R8 adv reset");

    // R1 busy bit reads back zero, other bits kept
    bus_write(1'b1, 32'hFFFF_FFFF);
    bus_read(1'b1, v); check(v == 32'hFFFF_FFFE, "R1 cmd readback", v, 32'hFFFF_FFFE);
    @(negedge clk);
    bus_write(1'b1, 32'h0000_5A53);
    bus_read(1'b1, v); check(v == 32'h0000_5A52, "R1 cmd readback2", v, 32'h0000_5A52);
    @(negedge clk);

    // R2 data register unchanged before the execution edge
    bus_write(1'b0, 32'h1234_5678);
    bus_write(1'b1, cmd_word(4'd0, 4'd2, 1'b0));
    bus_read(1'b0, v); check(v == 32'h1234_5678, "R2 before exec", v, 32'h1234_5678);
    @(negedge clk);
    bus_read(1'b0, v); check(v == 32'h0000_0044, "R2 after exec", v, 32'h0000_0044);

    // R3 address sweep: ID low read, marker kept on mismatch
    for (int c = 0; c < 16; c++) begin
      phy_addr = 4'(c);
      for (int a = 0; a < 16; a++) begin
        logic [31:0] e;
        bus_write(1'b0, 32'hDEAD_BEEF);
        phy_cmd(4'(a), 4'd3, 1'b0);
        bus_read(1'b0, v);
        e = (a == c) ? 32'h0000_1400 : 32'hDEAD_BEEF;
        check(v == e, (a == c) ? "R7 id match" : "R3 mismatch read", v, e);
      end
    end
    phy_addr = 4'd9;

    // R3 mismatched writes leave registers and data unchanged
    for (int a = 0; a < 16; a++) begin
      if (a == 9) continue;
      bus_write(1'b0, 32'h0000_0ABC);
      phy_cmd(4'(a), 4'd4, 1'b1);
      phy_cmd(4'(a), 4'd0, 1'b1);
      bus_read(1'b0, v); check(v == 32'h0000_0ABC, "R3 mismatch write data", v, 32'h0000_0ABC);
    end
    read_check(4'd4, "R3 adv untouched");
    read_check(4'd0, "R3 ctrl untouched");

    // R8 advertisement full width; R11 write command leaves data
    for (int i = 0; i < 8; i++) begin
      logic [15:0] d;
      d = 16'(16'hA5C3 ^ (i * 16'h1F11));
      phy_write(4'd4, d);
      bus_read(1'b0, v); check(v == {16'h0, d}, "R11 write keeps data", v, {16'h0, d});
      read_check(4'd4, "R8 adv write");
    end

    // R5 masked control stores, R4 self-reset also clears adv
    for (int i = 0; i < 12; i++) begin
      logic [15:0] d;
      d = 16'(16'h1357 * (i + 3));
      phy_write(4'd4, 16'hBEEF);
      phy_write(4'd0, d);
      read_check(4'd0, d[15] ? "R4 ctrl self reset" : "R5 ctrl masked");
      read_check(4'd4, d[15] ? "R4 adv cleared" : "R8 adv kept");
    end
    phy_write(4'd0, 16'h7FFF);
    read_check(4'd0, "R5 restart bit cleared");
    phy_write(4'd0, 16'h8000);
    read_check(4'd0, "R4 reset bit only");

    // R6 status follows link input
    link_up = 1'b0; read_check(4'd1, "R6 link down");
    link_up = 1'b1; read_check(4'd1, "R6 link up");
    phy_write(4'd0, 16'h8000);
    read_check(4'd1, "R4 link kept over reset");
    link_up = 1'b0; read_check(4'd1, "R6 link down again");

    // R7 R10 writes to read-only and unknown registers ignored
    phy_write(4'd0, 16'h0140);
    phy_write(4'd4, 16'h01E1);
    for (int r = 1; r < 16; r++) begin
      if (r == 4) continue;
      phy_write(4'(r), 16'hFFFF);
    end
    for (int r = 0; r < 16; r++) begin
      read_check(4'(r), (r == 5) ? "R9 partner" :
                        (r >= 6) ? "R10 unknown reads zero" :
                        (r == 2 || r == 3) ? "R7 id after write" : "R10 ro write ignored");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule